// File: doc/BRIEF.md
# Conditional Register Swap Sequencer

This block carries out a single instruction: swap two registers if a third register holds zero. It sits next to an ordinary register file of 32 words. That file has two asynchronous read ports and one synchronous write port, and it is left exactly as it is. The file stays outside the unit. The unit drives the two read addresses and the write port, and it takes the two read data buses back in.

One exchange cannot fit through a single write port in one cycle, so the unit runs it as a short sequence:

1. Read both operands into temporary latches.
2. Read the condition register and test it against zero.
3. If the test passes, write the operands back crossed over, one per cycle.

A non-zero condition ends the sequence after the test and touches nothing.

An issuing controller offers an instruction word together with a `start` strobe. It then waits for the one-cycle `done` pulse. While `busy` is high, further strobes are not taken.

Top module: `cswap_unit`

## Requirements
- R1: An instruction is accepted only at a clock edge where the unit is idle, `start` is high, bits 31:26 equal `SWAP_OPC` (default 6'h3B) and bits 10:0 are all zero. Bits 25:21 name the condition register, bits 20:16 operand A and bits 15:11 operand B. Any other word with `start` high is ignored: `busy` stays low and nothing is written.
- R2: When the condition register reads zero, register A ends up holding the old value of register B, and register B ends up holding the old value of register A.
- R3: When the condition register reads non-zero, the write enable stays low for the whole sequence, all registers are unchanged, and `done` appears in the 3rd cycle after the accepting edge.
- R4: In the 1st cycle after acceptance, read port A is addressed with operand A and read port B with operand B. In the 2nd cycle, read port A is addressed with the condition register.
- R5: For a swap, the 3rd cycle writes the latched old B into register A, and the 4th cycle writes the latched old A into register B. No write happens in any other cycle, and `done` appears in the 5th cycle.
- R6: `done` is high for exactly one cycle. `busy` is high from the 1st cycle up to and including the `done` cycle, and is low in the cycle after it. `start` and changes of the instruction word after acceptance have no effect on the running sequence.
- R7: The write enable is never raised for register 0. A swap that names register 0 as an operand updates only the other register, which then holds zero. Naming register 0 as the condition always swaps.
- R8: When both operands name the same register, its contents are unchanged.
- R9: A synchronous active-high reset returns the unit to idle, with `busy`, `done` and the write enable low in the following cycle. An operation in progress is abandoned without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to accept `instr` |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr_a | output | 5 | Register file read address, port A |
| rf_raddr_b | output | 5 | Register file read address, port B |
| rf_rdata_a | input | DATA_W | Register file read data, port A |
| rf_rdata_b | input | DATA_W | Register file read data, port B |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |

## Verification
The bench goes after the cases where the condition register is also one of the operands. A unit that tested the condition after its first write-back would then see a changed value, and either stop part way or swap when it should not. Equal operands and operands of register 0 are exercised as well. A unit that did not latch both old values would leave both registers holding the same value. A unit that did not suppress writes to register 0 would raise its write enable toward that register. A condition with only the top bit set catches a zero test that looks at too few bits. Wrong opcodes, stray strobes while busy, and a reset in mid-sequence catch a unit that accepts, restarts or finishes a write it should have dropped.

// File: rtl/swz_pkg.sv
package swz_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_AW  = 5;
    localparam int OPC_W   = 6;
    localparam int PAD_W   = INSTR_W - OPC_W - 3 * REG_AW;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_OPS,
        ST_TEST_COND,
        ST_PUT_B,
        ST_PUT_A,
        ST_FINISH
    } swz_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        reg_idx_t         cond;
        reg_idx_t         opa;
        reg_idx_t         opb;
        logic [PAD_W-1:0] pad;
    } swz_word_t;

    typedef struct packed {
        reg_idx_t cond;
        reg_idx_t opa;
        reg_idx_t opb;
    } swz_regs_t;

    function automatic logic word_matches(input logic [INSTR_W-1:0] w,
                                          input logic [OPC_W-1:0] opc);
        swz_word_t f;
        f = swz_word_t'(w);
        return (f.opc == opc) && (f.pad == '0);
    endfunction

    function automatic swz_regs_t word_regs(input logic [INSTR_W-1:0] w);
        swz_word_t f;
        swz_regs_t r;
        f      = swz_word_t'(w);
        r.cond = f.cond;
        r.opa  = f.opa;
        r.opb  = f.opb;
        return r;
    endfunction

endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
    import swz_pkg::*;
#(
    parameter logic [OPC_W-1:0] SWAP_OPC = 6'h3B
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               cond_zero,
    output swz_state_e         state,
    output swz_regs_t          held,
    output logic               busy,
    output logic               done
);

    swz_state_e nxt;
    logic       accept;

    assign accept = (state == ST_IDLE) && start && word_matches(instr_word, SWAP_OPC);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:      nxt = accept ? ST_FETCH_OPS : ST_IDLE;
            ST_FETCH_OPS: nxt = ST_TEST_COND;
            ST_TEST_COND: nxt = cond_zero ? ST_PUT_B : ST_FINISH;
            ST_PUT_B:     nxt = ST_PUT_A;
            ST_PUT_A:     nxt = ST_FINISH;
            ST_FINISH:    nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            held  <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                held <= word_regs(instr_word);
            end
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FINISH);

endmodule

// File: rtl/swz_oplatch.sv
module swz_oplatch #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [DATA_W-1:0] d_a,
    input  logic [DATA_W-1:0] d_b,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b
);

    localparam int LANES = 2;

    logic [LANES-1:0][DATA_W-1:0] din;
    logic [LANES-1:0][DATA_W-1:0] qout;

    assign din[0] = d_a;
    assign din[1] = d_b;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                qout[g] <= '0;
            end else if (cap) begin
                qout[g] <= din[g];
            end
        end
    end

    assign q_a = qout[0];
    assign q_b = qout[1];

endmodule

// File: rtl/swz_portmux.sv
module swz_portmux
    import swz_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  swz_state_e        state,
    input  swz_regs_t         held,
    input  logic [DATA_W-1:0] lat_a,
    input  logic [DATA_W-1:0] lat_b,
    output reg_idx_t          raddr_a,
    output reg_idx_t          raddr_b,
    output logic              we,
    output reg_idx_t          waddr,
    output logic [DATA_W-1:0] wdata
);

    logic wr_req;

    always_comb begin
        raddr_a = '0;
        raddr_b = '0;
        wr_req  = 1'b0;
        waddr   = '0;
        wdata   = '0;
        case (state)
            ST_FETCH_OPS: begin
                raddr_a = held.opa;
                raddr_b = held.opb;
            end
            ST_TEST_COND: begin
                raddr_a = held.cond;
            end
            ST_PUT_B: begin
                wr_req = 1'b1;
                waddr  = held.opa;
                wdata  = lat_b;
            end
            ST_PUT_A: begin
                wr_req = 1'b1;
                waddr  = held.opb;
                wdata  = lat_a;
            end
            default: begin
                wr_req = 1'b0;
            end
        endcase
    end

    assign we = wr_req && (waddr != '0);

endmodule

// File: rtl/cswap_unit.sv
module cswap_unit
    import swz_pkg::*;
#(
    parameter int               DATA_W   = 32,
    parameter logic [OPC_W-1:0] SWAP_OPC = 6'h3B
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    output logic               busy,
    output logic               done,
    output logic [REG_AW-1:0]  rf_raddr_a,
    output logic [REG_AW-1:0]  rf_raddr_b,
    input  logic [DATA_W-1:0]  rf_rdata_a,
    input  logic [DATA_W-1:0]  rf_rdata_b,
    output logic               rf_we,
    output logic [REG_AW-1:0]  rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata
);

    swz_state_e        state;
    swz_regs_t         held;
    logic [DATA_W-1:0] lat_a;
    logic [DATA_W-1:0] lat_b;
    logic              cond_zero;

    assign cond_zero = (rf_rdata_a == '0);

    swz_ctrl #(
        .SWAP_OPC (SWAP_OPC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .instr_word (instr),
        .cond_zero  (cond_zero),
        .state      (state),
        .held       (held),
        .busy       (busy),
        .done       (done)
    );

    swz_oplatch #(
        .DATA_W (DATA_W)
    ) u_latch (
        .clk (clk),
        .rst (rst),
        .cap (state == ST_FETCH_OPS),
        .d_a (rf_rdata_a),
        .d_b (rf_rdata_b),
        .q_a (lat_a),
        .q_b (lat_b)
    );

    swz_portmux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .state   (state),
        .held    (held),
        .lat_a   (lat_a),
        .lat_b   (lat_b),
        .raddr_a (rf_raddr_a),
        .raddr_b (rf_raddr_b),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata)
    );

endmodule

// File: rtl/cswap_unit_chk.sv
module cswap_unit_chk #(
    parameter int         DATA_W   = 32,
    parameter logic [5:0] SWAP_OPC = 6'h3B
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [31:0]       instr,
    input logic              busy,
    input logic              done,
    input logic [4:0]        rf_raddr_a,
    input logic [4:0]        rf_raddr_b,
    input logic [DATA_W-1:0] rf_rdata_a,
    input logic [DATA_W-1:0] rf_rdata_b,
    input logic              rf_we,
    input logic [4:0]        rf_waddr,
    input logic [DATA_W-1:0] rf_wdata
);

    logic              take;
    logic [2:0]        step;
    logic [4:0]        h_rs;
    logic [4:0]        h_rt;
    logic [4:0]        h_rd;
    logic [DATA_W-1:0] sav_a;
    logic [DATA_W-1:0] sav_b;

    assign take = !busy && start && (instr[31:26] == SWAP_OPC) && (instr[10:0] == 11'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            step  <= 3'd0;
            h_rs  <= '0;
            h_rt  <= '0;
            h_rd  <= '0;
            sav_a <= '0;
            sav_b <= '0;
        end else begin
            if (take) begin
                step <= 3'd1;
                h_rs <= instr[25:21];
                h_rt <= instr[20:16];
                h_rd <= instr[15:11];
            end else if (done) begin
                step <= 3'd0;
            end else if (step != 3'd0) begin
                step <= step + 3'd1;
            end
            if (step == 3'd1) begin
                sav_a <= rf_rdata_a;
                sav_b <= rf_rdata_b;
            end
        end
    end

    p_ignore_opc_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !take) |=> !busy);

    p_read_ops_r4: assert property (@(posedge clk) disable iff (rst)
        (step == 3'd1) |-> (rf_raddr_a == h_rt && rf_raddr_b == h_rd));

    p_read_cond_r4: assert property (@(posedge clk) disable iff (rst)
        (step == 3'd2) |-> (rf_raddr_a == h_rs));

    p_write_slot_r5: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (step == 3'd3 || step == 3'd4));

    p_write_b_r2: assert property (@(posedge clk) disable iff (rst)
        (step == 3'd3 && rf_we) |-> (rf_waddr == h_rt && rf_wdata == sav_b));

    p_write_a_r2: assert property (@(posedge clk) disable iff (rst)
        (step == 3'd4 && rf_we) |-> (rf_waddr == h_rd && rf_wdata == sav_a));

    p_skip_r3: assert property (@(posedge clk) disable iff (rst)
        (step == 3'd2 && rf_rdata_a != '0) |=> (done && !rf_we));

    p_done_step_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (step == 3'd3 || step == 3'd5));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_no_r0_write_r7: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != 5'd0));

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!busy && !done && !rf_we));

endmodule

bind cswap_unit cswap_unit_chk #(
    .DATA_W   (DATA_W),
    .SWAP_OPC (SWAP_OPC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .instr      (instr),
    .busy       (busy),
    .done       (done),
    .rf_raddr_a (rf_raddr_a),
    .rf_raddr_b (rf_raddr_b),
    .rf_rdata_a (rf_rdata_a),
    .rf_rdata_b (rf_rdata_b),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata)
);

// File: tb/test_cswap_unit.sv
module test_cswap_unit;

    localparam logic [5:0] OPC = 6'h3B;
    localparam int NV = 10;

    typedef struct packed {
        logic [4:0]  c;
        logic [4:0]  a;
        logic [4:0]  b;
        logic [31:0] cv;
        logic [31:0] av;
        logic [31:0] bv;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{5'd3,  5'd5,  5'd9,  32'h0000_0000, 32'hAAAA_0005, 32'hBBBB_0009},
        '{5'd3,  5'd6,  5'd7,  32'h0000_0001, 32'h1111_0006, 32'h2222_0007},
        '{5'd0,  5'd10, 5'd11, 32'h0000_0000, 32'h3333_000A, 32'h4444_000B},
        '{5'd4,  5'd12, 5'd13, 32'h8000_0000, 32'h5555_000C, 32'h6666_000D},
        '{5'd2,  5'd8,  5'd8,  32'h0000_0000, 32'h7777_0008, 32'h7777_0008},
        '{5'd1,  5'd0,  5'd14, 32'h0000_0000, 32'h0000_0000, 32'h8888_000E},
        '{5'd1,  5'd15, 5'd0,  32'h0000_0000, 32'h9999_000F, 32'h0000_0000},
        '{5'd20, 5'd20, 5'd21, 32'h0000_0000, 32'h0000_0000, 32'hCCCC_0015},
        '{5'd22, 5'd23, 5'd22, 32'h0000_0000, 32'hDDDD_0017, 32'h0000_0000},
        '{5'd31, 5'd30, 5'd29, 32'hFFFF_FFFF, 32'hEEEE_001E, 32'hFFFF_001D}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        busy, done;
    logic [4:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
    logic [31:0] rf_rdata_a, rf_rdata_b, rf_wdata;
    logic        rf_we;

    logic [31:0] rf   [32];
    logic [31:0] snap [32];
    logic [31:0] expv [32];
    logic        pl_we = 1'b0;
    logic [4:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cswap_unit i_cswap_unit (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .instr      (instr),
        .busy       (busy),
        .done       (done),
        .rf_raddr_a (rf_raddr_a),
        .rf_raddr_b (rf_raddr_b),
        .rf_rdata_a (rf_rdata_a),
        .rf_rdata_b (rf_rdata_b),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata)
    );

    assign rf_rdata_a = (rf_raddr_a == 5'd0) ? 32'd0 : rf[rf_raddr_a];
    assign rf_rdata_b = (rf_raddr_b == 5'd0) ? 32'd0 : rf[rf_raddr_b];

    always @(posedge clk) begin
        if (pl_we) begin
            rf[pl_addr] <= pl_data;
        end else if (rf_we && rf_waddr != 5'd0) begin
            rf[rf_waddr] <= rf_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] c,
                                       input logic [4:0] a, input logic [4:0] b);
        return {op, c, a, b, 11'd0};
    endfunction

    task automatic preload(input logic [4:0] addr, input logic [31:0] val);
        if (addr != 5'd0) begin
            @(negedge clk);
            pl_we = 1'b1; pl_addr = addr; pl_data = val;
            @(negedge clk);
            pl_we = 1'b0;
        end
    endtask

    task automatic take_snap();
        for (int i = 0; i < 32; i++) snap[i] = (i == 0) ? 32'd0 : rf[i];
    endtask

    task automatic cmp_regs(input string tag);
        int bad = -1;
        for (int i = 1; i < 32; i++) if (bad < 0 && rf[i] !== expv[i]) bad = i;
        if (bad < 0) chk(1'b1, tag, 32'd0, 32'd0);
        else chk(1'b0, tag, rf[bad], expv[bad]);
    endtask

    task automatic run_op(input logic [4:0] c, input logic [4:0] a, input logic [4:0] b);
        bit   zero;
        int   done_k = 0;
        bit   busy_bad = 1'b0;
        bit   wr_bad = 1'b0;
        bit   idle_bad = 1'b0;
        logic [31:0] old_a, old_b;
        take_snap();
        old_a = snap[a];
        old_b = snap[b];
        zero  = (snap[c] == 32'd0);
        for (int i = 0; i < 32; i++) expv[i] = snap[i];
        if (zero) begin
            expv[a] = old_b;
            expv[b] = old_a;
        end
        @(negedge clk);
        instr = mk(OPC, c, a, b);
        start = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 7; k++) begin
            if (k == 1) begin
                chk(rf_raddr_a == a && rf_raddr_b == b, "R4 operand read addresses",
                    {22'd0, rf_raddr_a, rf_raddr_b}, {22'd0, a, b});
            end
            if (k == 2) begin
                chk(rf_raddr_a == c, "R4 condition read address", {27'd0, rf_raddr_a}, {27'd0, c});
            end
            if (k == 3) begin
                chk(rf_we == (zero && a != 5'd0), "R5 R7 write enable cycle 3",
                    {31'd0, rf_we}, {31'd0, zero && a != 5'd0});
                if (rf_we) chk(rf_waddr == a && rf_wdata == old_b, "R5 R2 first write",
                               rf_wdata, old_b);
            end else if (k == 4) begin
                chk(rf_we == (zero && b != 5'd0), "R5 R7 write enable cycle 4",
                    {31'd0, rf_we}, {31'd0, zero && b != 5'd0});
                if (rf_we) chk(rf_waddr == b && rf_wdata == old_a, "R5 R2 second write",
                               rf_wdata, old_a);
            end else if (rf_we) begin
                wr_bad = 1'b1;
            end
            if (done_k == 0 && !busy) busy_bad = 1'b1;
            if (done_k != 0 && (busy || done)) idle_bad = 1'b1;
            if (done_k == 0 && done) done_k = k;
            start = (k < 3);
            instr = mk(OPC, 5'd0, 5'd1, 5'd2);
            @(negedge clk);
        end
        start = 1'b0;
        chk(done_k == (zero ? 5 : 3), zero ? "R5 swap latency" : "R3 skip latency", done_k, zero ? 5 : 3);
        chk(!wr_bad, "R5 R3 no write outside slots", {31'd0, wr_bad}, 32'd0);
        chk(!busy_bad && !idle_bad, "R6 busy and single done pulse", {30'd0, busy_bad, idle_bad}, 32'd0);
        if (!zero) cmp_regs("R3 registers unchanged");
        else if (a == b) cmp_regs("R8 same register unchanged");
        else if (a == 5'd0 || b == 5'd0) cmp_regs("R7 swap with r0");
        else cmp_regs("R2 exchanged contents");
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 32'h1000_0000 + i;
        rf[0] = 32'd0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !rf_we, "R9 reset state", {29'd0, busy, done, rf_we}, 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            preload(VECS[v].c, VECS[v].cv);
            preload(VECS[v].a, VECS[v].av);
            preload(VECS[v].b, VECS[v].bv);
            run_op(VECS[v].c, VECS[v].a, VECS[v].b);
        end

        // R1: wrong opcode, then nonzero pad bits, both with a condition that would swap
        for (int t = 0; t < 2; t++) begin
            bit seen_busy = 1'b0;
            bit seen_we = 1'b0;
            take_snap();
            for (int i = 0; i < 32; i++) expv[i] = snap[i];
            @(negedge clk);
            instr = (t == 0) ? mk(6'h3A, 5'd0, 5'd5, 5'd9) : (mk(OPC, 5'd0, 5'd5, 5'd9) | 32'h1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 5; k++) begin
                if (busy) seen_busy = 1'b1;
                if (rf_we) seen_we = 1'b1;
                @(negedge clk);
            end
            chk(!seen_busy && !seen_we, "R1 non-matching word ignored", {30'd0, seen_busy, seen_we}, 32'd0);
            cmp_regs("R1 registers untouched");
        end

        // R9: reset during the condition test aborts the swap
        take_snap();
        for (int i = 0; i < 32; i++) expv[i] = snap[i];
        @(negedge clk);
        instr = mk(OPC, 5'd0, 5'd16, 5'd17);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rf_we, "R9 reset aborts sequence", {29'd0, busy, done, rf_we}, 32'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && !rf_we, "R9 stays idle after abort", {30'd0, busy, rf_we}, 32'd0);
        cmp_regs("R9 no write after abort");

        // R6: back-to-back issue directly after completion
        run_op(5'd0, 5'd18, 5'd19);
        run_op(5'd0, 5'd18, 5'd19);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule